// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard controller of a dynamically scheduled floating-point pipeline. It sits next to a set of functional units: one integer unit, two multipliers, two adders and one divider by default. It decides, cycle by cycle, three things. First, whether the next in-order instruction may enter a unit. Second, when each occupied unit may fetch its source registers. Third, when each unit that has finished computing may drive its result onto the single result bus. The datapath, instruction fetch and the latency of each unit are outside the block. A unit reports the end of its computation with a one-cycle execution-done pulse.

There is no forwarding and no fixed interlock. The block keeps two tables. A per-unit status table holds busy, operation, destination, both source register numbers, producer tags and per-source ready flags. A register table records, for each register, which unit will write it next. Issue is refused when the unit class is full or the destination already has a pending writer, which removes structural and WAW hazards. An operand read waits until no earlier instruction still has to produce either source, which resolves RAW hazards. A result write waits until no other unit still has to read the old value of the destination, which resolves WAR hazards. Instructions therefore enter units in order but may execute and finish out of order.

Top module: `sb_hazard_ctl`

## Requirements
- R1: Operation codes are 0 integer, 1 multiply, 2 add, 3 subtract, 4 divide, and 5 to 7 are treated as integer. Unit indices are 0 integer, 1 and 2 multiply, 3 and 4 add/subtract, and 5 divide. An instruction is accepted (`issue_ok` high in the same cycle) only when a unit of its class is free and no active instruction has the same destination. The accepted unit is the lowest free index of the class. Otherwise the instruction waits, and it is accepted in the cycle after the blocking unit's write grant.
- R2: In the cycle after acceptance, the register table field for the destination holds the unit index plus one, and that unit's busy bit is set. The field for register r sits at `reg_tags[3*r +: 3]`, and 0 means no pending writer.
- R3: A unit's read grant is given only when neither of its sources is awaiting an earlier unit. A source that waits on a producer is released in the cycle after that producer's write grant. With no pending sources, the read grant comes in the cycle after acceptance.
- R4: Every accepted instruction receives exactly one read grant.
- R5: A unit's write grant is withheld while another busy unit still has a source equal to its destination that it has not yet read. The grant comes in the cycle after that read grant.
- R6: At most one write grant is given per cycle. Among eligible units the lowest index wins, and the others follow in later cycles.
- R7: A write grant clears the unit's busy bit and its destination's register table field at the next edge. A result becomes writable in the cycle after the unit's execution-done pulse.
- R8: An execution-done pulse to a unit that has not yet read its operands is ignored. The unit stays busy and later writes only after a fresh pulse that follows its read grant.
- R9: Each accepted instruction receives exactly one write grant, and only while its unit is busy.
- R10: While reset is held, no unit is busy, all register table fields are 0, and no read or write grant is given.
- R11: An instruction accepted in the same cycle as the write grant of its source's producer treats that source as ready. Its read grant follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 3 | Operation code |
| in_dst | input | RW | Destination register |
| in_src1 | input | RW | First source register |
| in_src2 | input | RW | Second source register |
| exec_done | input | NFU | Per-unit end-of-execution pulse |
| issue_ok | output | 1 | Instruction accepted this cycle (low means stall) |
| issue_unit | output | IW | Unit receiving the accepted instruction |
| rd_grant | output | NFU | Per-unit operand read permission |
| wr_grant | output | NFU | Per-unit result bus grant |
| fu_busy | output | NFU | Per-unit busy status |
| fu_op | output | NFU*3 | Per-unit stored operation |
| reg_tags | output | NREG*TW | Pending writer of each register, unit index plus one |

## Verification
Two pairs of events can land in the same cycle. In the first, two units become writable together. The bench holds both multipliers after their reads and then pulses both done lines on one edge. It expects the lower index to write in the next cycle and the other one cycle later. In the second, a result write coincides with the issue of an instruction that reads that result. The bench holds the integer unit, releases it, and presents the dependent add exactly in the write cycle. It judges by the add's read grant arriving one cycle later instead of deadlocking. The divide/add/subtract chain is judged by counted cycle numbers: the subtract finishes early but writes exactly one cycle after the add's read grant.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_INT = 3'd0;
  localparam logic [OP_W-1:0] OP_MUL = 3'd1;
  localparam logic [OP_W-1:0] OP_ADD = 3'd2;
  localparam logic [OP_W-1:0] OP_SUB = 3'd3;
  localparam logic [OP_W-1:0] OP_DIV = 3'd4;

  typedef enum logic [1:0] {
    CL_INT = 2'd0,
    CL_MUL = 2'd1,
    CL_ADD = 2'd2,
    CL_DIV = 2'd3
  } fu_class_e;

  // Which unit class executes an operation code.
  function automatic fu_class_e op_class(input logic [OP_W-1:0] op);
    case (op)
      OP_MUL:         return CL_MUL;
      OP_ADD, OP_SUB: return CL_ADD;
      OP_DIV:         return CL_DIV;
      default:        return CL_INT;
    endcase
  endfunction

  // Unit index layout: integer, multipliers, adders, divider.
  function automatic fu_class_e unit_class(input int idx, input int nmul, input int nadd);
    if (idx == 0)                return CL_INT;
    else if (idx <= nmul)        return CL_MUL;
    else if (idx <= nmul + nadd) return CL_ADD;
    else                         return CL_DIV;
  endfunction

  // A reader still owes a read of register dst.
  function automatic logic war_hit(input int src, input logic unread, input int dst);
    return unread && (src == dst);
  endfunction

endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
  import sb_pkg::*;
#(
  parameter int NUM_MUL = 2,
  parameter int NUM_ADD = 2,
  parameter int NFU     = 6,
  parameter int IW      = 3,
  parameter int TW      = 3
)(
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      in_op,
  input  logic [NFU-1:0]       busy,
  input  logic [TW-1:0]        dst_tag,
  output logic                 issue_ok,
  output logic [NFU-1:0]       issue_sel,
  output logic [IW-1:0]        issue_idx
);

  fu_class_e      want;
  logic           found;
  logic [NFU-1:0] pick;

  always_comb begin
    want      = op_class(in_op);
    found     = 1'b0;
    pick      = '0;
    issue_idx = '0;
    for (int i = 0; i < NFU; i++) begin
      if (!found && !busy[i] && unit_class(i, NUM_MUL, NUM_ADD) == want) begin
        found     = 1'b1;
        pick[i]   = 1'b1;
        issue_idx = IW'(i);
      end
    end
    issue_ok  = in_valid && found && (dst_tag == '0);
    issue_sel = issue_ok ? pick : '0;
  end

endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int RW = 4,
  parameter int TW = 3
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_en,
  input  logic [OP_W-1:0] op_in,
  input  logic [RW-1:0]   dst_in,
  input  logic [RW-1:0]   src1_in,
  input  logic [RW-1:0]   src2_in,
  input  logic [TW-1:0]   qj_in,
  input  logic [TW-1:0]   qk_in,
  input  logic [TW-1:0]   wr_tag,
  input  logic            wr_self,
  input  logic            exec_done,
  output logic            busy,
  output logic [OP_W-1:0] op_q,
  output logic [RW-1:0]   fi,
  output logic [RW-1:0]   fj,
  output logic [RW-1:0]   fk,
  output logic            rj,
  output logic            rk,
  output logic            rd_req,
  output logic            done_q
);

  logic [TW-1:0] qj, qk;
  logic          read_q;

  assign rd_req = busy && !read_q && rj && rk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      op_q   <= '0;
      fi     <= '0;
      fj     <= '0;
      fk     <= '0;
      qj     <= '0;
      qk     <= '0;
      rj     <= 1'b0;
      rk     <= 1'b0;
      read_q <= 1'b0;
      done_q <= 1'b0;
    end else if (issue_en) begin
      busy   <= 1'b1;
      op_q   <= op_in;
      fi     <= dst_in;
      fj     <= src1_in;
      fk     <= src2_in;
      qj     <= qj_in;
      qk     <= qk_in;
      rj     <= (qj_in == '0);
      rk     <= (qk_in == '0);
      read_q <= 1'b0;
      done_q <= 1'b0;
    end else if (wr_self) begin
      busy   <= 1'b0;
      rj     <= 1'b0;
      rk     <= 1'b0;
      read_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (rd_req) begin
        rj     <= 1'b0;
        rk     <= 1'b0;
        read_q <= 1'b1;
      end else begin
        if (wr_tag != '0 && qj == wr_tag) begin
          rj <= 1'b1;
          qj <= '0;
        end
        if (wr_tag != '0 && qk == wr_tag) begin
          rk <= 1'b1;
          qk <= '0;
        end
      end
      if (exec_done && read_q && !done_q)
        done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int N = 6
)(
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic taken;

  always_comb begin
    gnt   = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sb_hazard_ctl.sv
module sb_hazard_ctl
  import sb_pkg::*;
#(
  parameter int NUM_MUL = 2,
  parameter int NUM_ADD = 2,
  parameter int NREG    = 16,
  localparam int NFU    = NUM_MUL + NUM_ADD + 2,
  localparam int RW     = $clog2(NREG),
  localparam int IW     = $clog2(NFU),
  localparam int TW     = $clog2(NFU + 1)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      in_op,
  input  logic [RW-1:0]        in_dst,
  input  logic [RW-1:0]        in_src1,
  input  logic [RW-1:0]        in_src2,
  input  logic [NFU-1:0]       exec_done,
  output logic                 issue_ok,
  output logic [IW-1:0]        issue_unit,
  output logic [NFU-1:0]       rd_grant,
  output logic [NFU-1:0]       wr_grant,
  output logic [NFU-1:0]       fu_busy,
  output logic [NFU*OP_W-1:0]  fu_op,
  output logic [NREG*TW-1:0]   reg_tags
);

  // register result table
  logic [TW-1:0] owner [NREG];

  // per-unit status, brought out as named wires
  logic [NFU-1:0][RW-1:0]   fi_v, fj_v, fk_v;
  logic [NFU-1:0][OP_W-1:0] op_v;
  logic [NFU-1:0]           busy_v, rj_v, rk_v, rd_req_v, done_v;
  logic [NFU-1:0]           issue_sel, war_ok, wr_req;

  // writeback event
  logic          wr_any;
  logic [TW-1:0] wr_tag;
  logic [RW-1:0] wr_fi;

  // issue-side tag lookups
  logic [TW-1:0] dst_tag, own_s1, own_s2, qj_new, qk_new;

  assign dst_tag = owner[in_dst];
  assign own_s1  = owner[in_src1];
  assign own_s2  = owner[in_src2];
  // a producer writing this very cycle is treated as already done
  assign qj_new  = (wr_any && own_s1 == wr_tag) ? '0 : own_s1;
  assign qk_new  = (wr_any && own_s2 == wr_tag) ? '0 : own_s2;

  sb_issue_ctl #(
    .NUM_MUL(NUM_MUL), .NUM_ADD(NUM_ADD), .NFU(NFU), .IW(IW), .TW(TW)
  ) u_issue (
    .in_valid (in_valid),
    .in_op    (in_op),
    .busy     (busy_v),
    .dst_tag  (dst_tag),
    .issue_ok (issue_ok),
    .issue_sel(issue_sel),
    .issue_idx(issue_unit)
  );

  for (genvar g = 0; g < NFU; g++) begin : g_fu
    sb_fu_entry #(.RW(RW), .TW(TW)) u_fu (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_en (issue_sel[g]),
      .op_in    (in_op),
      .dst_in   (in_dst),
      .src1_in  (in_src1),
      .src2_in  (in_src2),
      .qj_in    (qj_new),
      .qk_in    (qk_new),
      .wr_tag   (wr_tag),
      .wr_self  (wr_grant[g]),
      .exec_done(exec_done[g]),
      .busy     (busy_v[g]),
      .op_q     (op_v[g]),
      .fi       (fi_v[g]),
      .fj       (fj_v[g]),
      .fk       (fk_v[g]),
      .rj       (rj_v[g]),
      .rk       (rk_v[g]),
      .rd_req   (rd_req_v[g]),
      .done_q   (done_v[g])
    );
  end

  // WAR gate: nobody may still owe a read of the old destination value
  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      war_ok[u] = 1'b1;
      for (int f = 0; f < NFU; f++) begin
        if (f != u && busy_v[f] &&
            (war_hit(int'(fj_v[f]), rj_v[f], int'(fi_v[u])) ||
             war_hit(int'(fk_v[f]), rk_v[f], int'(fi_v[u]))))
          war_ok[u] = 1'b0;
      end
      wr_req[u] = busy_v[u] && done_v[u] && war_ok[u];
    end
  end

  sb_wb_arb #(.N(NFU)) u_arb (
    .req(wr_req),
    .gnt(wr_grant)
  );

  always_comb begin
    wr_any = |wr_grant;
    wr_tag = '0;
    wr_fi  = '0;
    for (int i = 0; i < NFU; i++) begin
      if (wr_grant[i]) begin
        wr_tag = TW'(i + 1);
        wr_fi  = fi_v[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) owner[r] <= '0;
    end else begin
      if (wr_any)   owner[wr_fi]  <= '0;
      if (issue_ok) owner[in_dst] <= TW'(issue_unit) + TW'(1);
    end
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) reg_tags[r*TW +: TW] = owner[r];
  end

  assign rd_grant = rd_req_v;
  assign fu_busy  = busy_v;
  assign fu_op    = op_v;

endmodule

module sb_hazard_ctl_chk #(
  parameter int NFU  = 6,
  parameter int NREG = 16,
  parameter int RW   = 4,
  parameter int IW   = 3,
  parameter int TW   = 3
)(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    issue_ok,
  input logic [IW-1:0]           issue_unit,
  input logic [RW-1:0]           in_dst,
  input logic [NREG*TW-1:0]      reg_tags,
  input logic [NFU-1:0]          fu_busy,
  input logic [NFU-1:0]          rd_grant,
  input logic [NFU-1:0]          wr_grant,
  input logic [NFU-1:0][RW-1:0]  fi_v,
  input logic [NFU-1:0][RW-1:0]  fj_v,
  input logic [NFU-1:0][RW-1:0]  fk_v,
  input logic [NFU-1:0]          rj_v,
  input logic [NFU-1:0]          rk_v
);

  logic [RW-1:0]  prev_dst;
  logic [IW-1:0]  prev_unit;
  logic [TW-1:0]  own_prev;
  logic [NFU-1:0] war_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dst  <= '0;
      prev_unit <= '0;
    end else begin
      prev_dst  <= in_dst;
      prev_unit <= issue_unit;
    end
  end

  assign own_prev = reg_tags[int'(prev_dst)*TW +: TW];

  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      war_bad[u] = 1'b0;
      for (int f = 0; f < NFU; f++)
        if (f != u && fu_busy[f] &&
            ((fj_v[f] == fi_v[u] && rj_v[f]) || (fk_v[f] == fi_v[u] && rk_v[f])))
          war_bad[u] = 1'b1;
    end
  end

  assert_issue_free_unit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |-> !fu_busy[issue_unit]);

  assert_issue_claims_dst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |=> (int'(own_prev) == int'(prev_unit) + 1) && fu_busy[prev_unit]);

  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_grant));

  for (genvar u = 0; u < NFU; u++) begin : g_chk
    assert_read_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[u] |=> !rd_grant[u]);

    assert_war_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant[u] |-> !war_bad[u]);

    assert_free_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fu_busy[u]) |-> $past(wr_grant[u]));

    assert_write_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant[u] |-> fu_busy[u] && !rd_grant[u]);
  end

endmodule

bind sb_hazard_ctl sb_hazard_ctl_chk #(
  .NFU(NFU), .NREG(NREG), .RW(RW), .IW(IW), .TW(TW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_ok  (issue_ok),
  .issue_unit(issue_unit),
  .in_dst    (in_dst),
  .reg_tags  (reg_tags),
  .fu_busy   (fu_busy),
  .rd_grant  (rd_grant),
  .wr_grant  (wr_grant),
  .fi_v      (fi_v),
  .fj_v      (fj_v),
  .fk_v      (fk_v),
  .rj_v      (rj_v),
  .rk_v      (rk_v)
);

// File: tb/sb_hazard_ctl_test.sv
module sb_hazard_ctl_test;

  localparam int NFU  = 6;
  localparam int NREG = 16;
  localparam int RW   = 4;
  localparam int IW   = 3;
  localparam int TW   = 3;

  localparam logic [2:0] C_INT = 3'd0, C_MUL = 3'd1, C_ADD = 3'd2, C_SUB = 3'd3, C_DIV = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_op = '0;
  logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [NFU-1:0] model_done = '0, force_done = '0, exec_done;
  logic issue_ok;
  logic [IW-1:0] issue_unit;
  logic [NFU-1:0] rd_grant, wr_grant, fu_busy;
  logic [NFU*3-1:0] fu_op;
  logic [NREG*TW-1:0] reg_tags;

  assign exec_done = model_done | force_done;

  sb_hazard_ctl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .exec_done(exec_done), .issue_ok(issue_ok), .issue_unit(issue_unit),
    .rd_grant(rd_grant), .wr_grant(wr_grant), .fu_busy(fu_busy),
    .fu_op(fu_op), .reg_tags(reg_tags)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int rd_cnt = 0, wr_cnt = 0, iss_cnt = 0;
  int last_rd [NFU];
  int last_wr [NFU];
  int lat [NFU];
  int cnt [NFU];

  always @(posedge clk) cyc = cyc + 1;

  // event monitor, samples between edges
  always @(negedge clk) begin
    #2;
    for (int u = 0; u < NFU; u++) begin
      if (rd_grant[u]) begin last_rd[u] = cyc; rd_cnt++; end
      if (wr_grant[u]) begin last_wr[u] = cyc; wr_cnt++; end
    end
  end

  // execution latency model; lat 0 holds the unit until forced
  always @(negedge clk) begin
    #3;
    for (int u = 0; u < NFU; u++) begin
      model_done[u] = 1'b0;
      if (cnt[u] == 1) begin model_done[u] = 1'b1; cnt[u] = 0; end
      else if (cnt[u] > 1) cnt[u]--;
      if (rd_grant[u] && lat[u] > 0) cnt[u] = lat[u];
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tag_of(input int r);
    return int'(reg_tags[r*TW +: TW]);
  endfunction

  task automatic do_issue(input logic [2:0] op, input int d, input int s1, input int s2,
                          output int c, output int u);
    int n;
    @(negedge clk);
    #1;
    in_valid = 1'b1; in_op = op;
    in_dst = RW'(d); in_src1 = RW'(s1); in_src2 = RW'(s2);
    n = 0;
    c = -1; u = -1;
    forever begin
      #1;
      if (issue_ok) begin c = cyc; u = int'(issue_unit); break; end
      n++;
      if (n > 300) break;
      @(negedge clk);
      #1;
    end
    chk("R1", "issue accepted", int'(c >= 0), 1);
    if (c >= 0) iss_cnt++;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk); #2;
    while (fu_busy != '0 && n < 400) begin
      @(negedge clk); #2;
      n++;
    end
    chk("R7", "all units drained", int'(fu_busy), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, u, c2, u2, k, k2, pre;
    for (int i = 0; i < NFU; i++) begin last_rd[i] = -1; last_wr[i] = -1; cnt[i] = 0; end
    lat[0] = 1; lat[1] = 10; lat[2] = 10; lat[3] = 2; lat[4] = 2; lat[5] = 40;

    // R10: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R10", "busy in reset", int'(fu_busy), 0);
    chk("R10", "reg table in reset", int'(reg_tags != '0), 0);
    chk("R10", "grants in reset", int'(rd_grant | wr_grant), 0);
    @(negedge clk); #1; rst_n = 1'b1;

    // R1: no valid, no issue
    in_op = C_DIV; in_dst = 4'd3;
    repeat (2) @(negedge clk);
    #2;
    chk("R1", "issue without valid", int'(issue_ok), 0);
    chk("R1", "busy without valid", int'(fu_busy), 0);

    // divide / add / subtract chain
    do_issue(C_DIV, 0, 2, 4, c, u);
    chk("R1", "divide unit", u, 5);
    @(negedge clk); #2;
    chk("R2", "f0 owner after divide", tag_of(0), 6);
    chk("R2", "divider busy", int'(fu_busy[5]), 1);
    do_issue(C_ADD, 6, 0, 8, c, u);
    chk("R1", "add unit", u, 3);
    do_issue(C_SUB, 8, 10, 12, c, u);
    chk("R1", "subtract unit is second adder", u, 4);
    wait_idle();
    chk("R7", "divide writes after latency", last_wr[5], last_rd[5] + 41);
    chk("R3", "add reads after divide write", last_rd[3], last_wr[5] + 1);
    chk("R5", "subtract held before add read", int'(last_rd[4] + 3 < last_wr[4]), 1);
    chk("R5", "subtract writes after add read", last_wr[4], last_rd[3] + 1);
    chk("R7", "f0 owner cleared", tag_of(0), 0);
    chk("R7", "f8 owner cleared", tag_of(8), 0);

    // WAW stall
    do_issue(C_MUL, 2, 1, 3, c, u);
    chk("R1", "multiply unit", u, 1);
    do_issue(C_ADD, 2, 4, 5, c, u);
    chk("R1", "WAW issue after write", c, last_wr[1] + 1);
    wait_idle();

    // structural stall
    do_issue(C_MUL, 10, 13, 13, c, u);
    do_issue(C_MUL, 11, 13, 13, c2, u2);
    chk("R1", "second multiply lowest free", u2, 2);
    do_issue(C_MUL, 12, 13, 13, c, u);
    chk("R1", "third multiply unit", u, 1);
    chk("R1", "third multiply after free", c, last_wr[1] + 1);
    wait_idle();

    // R6: simultaneous completion
    lat[1] = 0; lat[2] = 0;
    do_issue(C_MUL, 1, 3, 3, c, u);
    do_issue(C_MUL, 2, 3, 3, c, u);
    repeat (3) @(negedge clk);
    @(negedge clk); #3; force_done = 6'b000110; k = cyc;
    @(negedge clk); #3; force_done = '0;
    lat[1] = 10; lat[2] = 10;
    wait_idle();
    chk("R6", "lower index writes first", last_wr[1], k + 1);
    chk("R6", "higher index writes next", last_wr[2], k + 2);

    // R8: early done ignored
    lat[0] = 0;
    do_issue(C_INT, 9, 1, 1, c, u);
    do_issue(C_ADD, 14, 9, 1, c, u);
    pre = last_wr[3];
    repeat (2) @(negedge clk);
    @(negedge clk); #3; force_done = 6'b001000;
    @(negedge clk); #3; force_done = '0;
    repeat (5) @(negedge clk);
    #2;
    chk("R8", "adder still busy", int'(fu_busy[3]), 1);
    chk("R8", "adder not written", last_wr[3], pre);
    @(negedge clk); #3; force_done = 6'b000001; k2 = cyc;
    @(negedge clk); #3; force_done = '0;
    wait_idle();
    chk("R8", "integer write", last_wr[0], k2 + 1);
    chk("R3", "adder read after producer", last_rd[3], k2 + 2);
    chk("R8", "adder writes after real done", last_wr[3], k2 + 5);

    // R11: issue in producer's write cycle
    do_issue(C_INT, 5, 1, 1, c, u);
    repeat (2) @(negedge clk);
    @(negedge clk); #3; force_done = 6'b000001; k = cyc;
    fork
      begin @(negedge clk); #3; force_done = '0; end
    join_none
    do_issue(C_ADD, 7, 5, 6, c, u);
    chk("R11", "dependent issue cycle", c, k + 1);
    lat[0] = 1;
    wait_idle();
    chk("R11", "producer write cycle", last_wr[0], k + 1);
    chk("R11", "dependent reads next cycle", last_rd[3], k + 2);

    // R4 / R9 totals
    repeat (2) @(negedge clk);
    chk("R4", "one read per instruction", rd_cnt, iss_cnt);
    chk("R9", "one write per instruction", wr_cnt, iss_cnt);
    chk("R7", "register table empty", int'(reg_tags != '0), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule